// File: doc/BRIEF.md
# Prescaled Successive-Approximation Conversion Sequencer

This block runs the timing of a single 10-bit successive-approximation conversion. It does not contain the analog parts. It drives a sample-hold control and a trial code for an external DAC. It reads back one comparator decision bit and builds the result from the most significant bit down to the least significant bit.

All pacing comes from a machine-cycle strobe, `mcEn`. A free-running divider counts these strobes and produces the bit-period ticks. A 2-bit select, `preSel`, picks the divisor m from {2, 4, 6, 8}, so the block can be matched to different system clock rates.

A start pulse arms the block. Sampling then begins at the next bit-period tick, so the point where sampling starts moves by up to half a divisor of machine cycles, depending on where the divider is when the start arrives. A conversion has three parts:

- sampling, lasting two bit periods;
- ten decision periods, one per result bit;
- one final machine cycle, which stores the result.

The block reports progress with a busy flag and a done pulse.

Top module: `sar_conv_timer`

## Requirements
- R1: `preSel` values 0, 1, 2 and 3 select m = 2, 4, 6 and 8. One bit period lasts m/2 strobes of `mcEn`. The state advances only on clocks where `mcEn` is 1.
- R2: Counted in `mcEn` strobes, a conversion lasts exactly 6·m+1 strobes. The count runs from the first clock in which `sampleHold` is high up to and including the strobe that stores the result.
- R3: `sampleHold` is 1 for exactly m `mcEn` strobes (two bit periods) in each conversion, and it is 0 at all other times.
- R4: `dacCode` is 0 while sampling. The first trial code after sampling is 0x200. The decisions run from bit 9 down to bit 0. A `cmpIn` of 1 means the input is at or above the trial code, and the trial bit is kept. A `cmpIn` of 0 clears the trial bit.
- R5: With `cmpIn` = (input ≥ `dacCode`), the stored `result` equals the input value for any input from 0 to 1023.
- R6: The number of `mcEn` strobes from the clock after the start is accepted up to the clock in which `sampleHold` rises lies between 1 and m/2, inclusive.
- R7: `storeStrobe` and `donePulse` are high together for exactly one clock, the clock after the final store strobe. In that clock `result` already holds the new value and `busy` is 0.
- R8: A `startReq` that arrives while `busy` is 1 is ignored. When the conversion in progress ends, no further conversion starts.
- R9: While reset is held and after it is released, `busy`, `sampleHold`, `storeStrobe` and `donePulse` are 0, and `dacCode` and `result` are 0.
- R10: `result` changes only in a clock where `storeStrobe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| mcEn | input | 1 | Machine-cycle strobe, one clock wide |
| preSel | input | 2 | Prescaler select; m = 2·(preSel+1); hold stable while busy |
| startReq | input | 1 | Start request; taken only when idle |
| cmpIn | input | 1 | Comparator decision: 1 when the input is at or above `dacCode` |
| sampleHold | output | 1 | High during the sampling phase |
| dacCode | output | 10 | Trial code for the DAC |
| busy | output | 1 | High from start acceptance until the result is stored |
| result | output | 10 | Last stored conversion result |
| storeStrobe | output | 1 | One-clock pulse as a new result is stored |
| donePulse | output | 1 | One-clock pulse at the end of a conversion |

## Verification
The conversion is run with all four prescaler selects. Each select is combined with machine-cycle strobes arriving every clock, every second clock or every third clock, and with different divider phases at the moment of start. This separates the effect of the divisor from the effect of the strobe rate and from the effect of the start alignment.

The input values used are:

- 0 and 1023, which test the kept and cleared extremes of every bit;
- the alternating patterns 0x155 and 0x2AA, which expose a swapped or misordered bit decision;
- the values around the most significant bit transition (0x1FF and 0x200), which expose an error in the first trial;
- 0x001 and 0x3FE, which expose an off-by-one in the last decision.

Two directed runs raise a start request in the middle of a conversion and then watch for a spurious restart.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SAMPLE,
    ST_CONV,
    ST_STORE
  } sarState_t;

  typedef struct packed {
    logic loadMsb;
    logic decide;
    logic storeRes;
  } sarCtrl_t;

endpackage

// File: rtl/sar_bit_clock.sv
module sar_bit_clock #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mcEn,
  input  logic [SEL_W-1:0] preSel,
  output logic             bitTick
);
  localparam int DIV_W = SEL_W + 1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfLast;
  logic             atLast;

  // half divisor minus one: preSel directly
  assign halfLast = DIV_W'(preSel);
  assign atLast   = (divCnt >= halfLast);
  assign bitTick  = mcEn && atLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (mcEn) begin
      if (atLast) divCnt <= '0;
      else        divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_control.sv
module sar_control
  import sar_conv_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     mcEn,
  input  logic     bitTick,
  input  logic     startReq,
  output sarCtrl_t ctrl,
  output logic     busy,
  output logic     sampleHold,
  output logic     donePulse
);
  localparam int CNT_W = $clog2(RES_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(RES_W - 1);
  localparam logic [CNT_W-1:0] LAST_SMP = CNT_W'(1);

  sarState_t       state;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) state <= ST_ARM;
        end
        ST_ARM: begin
          if (bitTick) begin
            state  <= ST_SAMPLE;
            bitCnt <= '0;
          end
        end
        ST_SAMPLE: begin
          if (bitTick) begin
            if (bitCnt == LAST_SMP) begin
              state  <= ST_CONV;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (bitTick) begin
            if (bitCnt == LAST_BIT) state <= ST_STORE;
            else                    bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_STORE: begin
          if (mcEn) begin
            state     <= ST_IDLE;
            donePulse <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.loadMsb  = (state == ST_SAMPLE) && bitTick && (bitCnt == LAST_SMP);
    ctrl.decide   = (state == ST_CONV) && bitTick;
    ctrl.storeRes = (state == ST_STORE) && mcEn;
  end

  assign busy       = (state != ST_IDLE);
  assign sampleHold = (state == ST_SAMPLE);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_conv_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarCtrl_t         ctrl,
  input  logic             cmpIn,
  output logic [RES_W-1:0] dacCode,
  output logic [RES_W-1:0] result,
  output logic             storeStrobe
);
  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] sarReg;
  logic [RES_W-1:0] trialPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sarReg      <= '0;
      trialPtr    <= '0;
      result      <= '0;
      storeStrobe <= 1'b0;
    end else begin
      storeStrobe <= ctrl.storeRes;
      if (ctrl.loadMsb) begin
        sarReg   <= MSB_ONE;
        trialPtr <= MSB_ONE;
      end else if (ctrl.decide) begin
        sarReg   <= (cmpIn ? sarReg : (sarReg & ~trialPtr)) | (trialPtr >> 1);
        trialPtr <= trialPtr >> 1;
      end else if (ctrl.storeRes) begin
        result   <= sarReg;
        sarReg   <= '0;
        trialPtr <= '0;
      end
    end
  end

  assign dacCode = sarReg;
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer
  import sar_conv_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mcEn,
  input  logic [SEL_W-1:0] preSel,
  input  logic             startReq,
  input  logic             cmpIn,
  output logic             sampleHold,
  output logic [RES_W-1:0] dacCode,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             storeStrobe,
  output logic             donePulse
);
  sarCtrl_t ctrl;
  logic     bitTick;

  sar_bit_clock #(.SEL_W(SEL_W)) i_bitClock (
    .clk(clk), .rstN(rstN), .mcEn(mcEn), .preSel(preSel), .bitTick(bitTick)
  );

  sar_control #(.RES_W(RES_W)) i_control (
    .clk(clk), .rstN(rstN), .mcEn(mcEn), .bitTick(bitTick),
    .startReq(startReq), .ctrl(ctrl), .busy(busy),
    .sampleHold(sampleHold), .donePulse(donePulse)
  );

  sar_datapath #(.RES_W(RES_W)) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cmpIn(cmpIn),
    .dacCode(dacCode), .result(result), .storeStrobe(storeStrobe)
  );
endmodule

// File: rtl/sar_conv_timer_chk.sv
module sar_conv_timer_chk #(
  parameter int RES_W = 10,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             mcEn,
  input logic [SEL_W-1:0] preSel,
  input logic             sampleHold,
  input logic [RES_W-1:0] dacCode,
  input logic             busy,
  input logic [RES_W-1:0] result,
  input logic             storeStrobe,
  input logic             donePulse
);
  logic       prevHold;
  logic [7:0] mcCount;
  logic [7:0] expLen;

  assign expLen = 8'(6 * 2 * (int'(preSel) + 1) + 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevHold <= 1'b0;
      mcCount  <= '0;
    end else begin
      prevHold <= sampleHold;
      if (sampleHold && !prevHold) mcCount <= mcEn ? 8'd1 : 8'd0;
      else if (busy && mcEn)       mcCount <= mcCount + 8'd1;
    end
  end

  AST_HOLD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |-> busy); // R3
  AST_SAMPLE_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleHold) |-> $past(mcEn)); // R1
  AST_DAC_ZERO_SAMPLING: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |-> (dacCode == '0)); // R4
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (mcCount == expLen)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R7
  AST_STORE_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    storeStrobe |-> (donePulse && !busy)); // R7
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !storeStrobe |-> $stable(result)); // R10
endmodule

bind sar_conv_timer sar_conv_timer_chk #(.RES_W(RES_W), .SEL_W(SEL_W)) i_chk (
  .clk(clk), .rstN(rstN), .mcEn(mcEn), .preSel(preSel),
  .sampleHold(sampleHold), .dacCode(dacCode), .busy(busy),
  .result(result), .storeStrobe(storeStrobe), .donePulse(donePulse)
);

// File: tb/test_sar_conv_timer.sv
module test_sar_conv_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mcEn = 1'b0;
  logic [1:0] preSel = 2'd0;
  logic       startReq = 1'b0;
  logic       cmpIn;
  logic       sampleHold, busy, storeStrobe, donePulse;
  logic [9:0] dacCode, result;
  logic [9:0] analogVal = 10'd0;
  int         mcDiv = 1;
  int         mcCnt = 0;
  int         checks = 0;
  int         failures = 0;
  bit         finished = 1'b0;

  // {preSel[1:0], strobe spacing[1:0], value[9:0]}
  localparam logic [13:0] VEC [8] = '{
    {2'd0, 2'd1, 10'h000}, {2'd1, 2'd1, 10'h3FF},
    {2'd2, 2'd3, 10'h155}, {2'd3, 2'd3, 10'h2AA},
    {2'd0, 2'd3, 10'h200}, {2'd1, 2'd2, 10'h1FF},
    {2'd2, 2'd1, 10'h001}, {2'd3, 2'd2, 10'h3FE}
  };

  always #10 clk = ~clk;

  assign cmpIn = (analogVal >= dacCode);

  sar_conv_timer i_sar_conv_timer (
    .clk(clk), .rstN(rstN), .mcEn(mcEn), .preSel(preSel),
    .startReq(startReq), .cmpIn(cmpIn), .sampleHold(sampleHold),
    .dacCode(dacCode), .busy(busy), .result(result),
    .storeStrobe(storeStrobe), .donePulse(donePulse)
  );

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mcCnt >= mcDiv - 1) begin mcCnt = 0; mcEn = 1'b1; end
      else begin mcCnt++; mcEn = 1'b0; end
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic runConv(input logic [1:0] sel, input int spacing,
                         input logic [9:0] val, input bit midStart);
    int halfM, m, lat, holdCnt, total, iter;
    bit dacOk;
    logic [9:0] keep;
    preSel = sel; analogVal = val; mcDiv = spacing;
    halfM = int'(sel) + 1; m = 2 * halfM;
    @(posedge clk); #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
    @(negedge clk);
    lat = 0;
    while (!sampleHold) begin
      if (mcEn) lat++;
      @(negedge clk);
    end
    check("R6 start-to-sample latency", lat >= 1 && lat <= halfM, lat, halfM);
    holdCnt = 0; dacOk = 1'b1;
    while (sampleHold) begin
      if (dacCode != 10'd0) dacOk = 1'b0;
      if (mcEn) holdCnt++;
      @(negedge clk);
    end
    check("R3 sample phase length", holdCnt == m, holdCnt, m);
    check("R4 first trial code", dacCode == 10'h200 && dacOk, int'(dacCode), 'h200);
    total = holdCnt; iter = 0;
    while (!donePulse) begin
      if (mcEn) total++;
      if (midStart) startReq = (iter == 2);
      iter++;
      @(negedge clk);
    end
    startReq = 1'b0;
    check("R2 conversion length", total == 6 * m + 1, total, 6 * m + 1);
    check("R1 R5 result value", result == val, int'(result), int'(val));
    check("R7 busy low at done", !busy && storeStrobe, int'(busy), 0);
    @(negedge clk);
    check("R7 single-cycle pulses", !donePulse && !storeStrobe, int'(donePulse), 0);
    if (midStart) begin
      keep = result;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (busy) break;
      end
      check("R8 no restart after ignored start", !busy, int'(busy), 0);
      check("R10 result held", result == keep, int'(result), int'(keep));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9 reset busy", !busy && !sampleHold, int'(busy), 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check("R9 reset busy/hold", !busy && !sampleHold, int'(busy), 0);
    check("R9 reset pulses", !donePulse && !storeStrobe, int'(donePulse), 0);
    check("R9 reset codes", dacCode == 0 && result == 0, int'(result), 0);
    for (int i = 0; i < 8; i++)
      runConv(VEC[i][13:12], int'(VEC[i][11:10]), VEC[i][9:0], 1'b0);
    runConv(2'd3, 3, 10'h3FF, 1'b1);
    runConv(2'd0, 1, 10'h000, 1'b1);
    runConv(2'd1, 2, 10'h2D3, 1'b0);
    finishRun();
  end
endmodule